// File: doc/BRIEF.md
# CAN Mailbox Transmit Request and Cancel Registers

This block holds the two 16-bit control registers that a CAN controller uses to queue and withdraw transmissions from fifteen mailboxes, numbered 1 to 15. The pending register marks each mailbox that is waiting to win bus arbitration. The cancel register marks each mailbox whose queued frame software wants withdrawn. Software reaches both registers through a simple synchronous read/write port. A write of 1 sets a flag. A write of 0 leaves it unchanged, so software cannot clear a pending flag itself.

The protocol engine drives two pulse vectors into the block, one for transmit completion and one for cancel completion. It reads two flag vectors back, indexed by mailbox. A pending flag clears when its mailbox finishes transmitting or when its cancellation completes. A cancel flag clears only once the matching pending flag is gone. This makes withdrawal a two-register handshake.

In the register image, mailboxes sit byte-swapped. Mailboxes 1 to 7 occupy the upper byte and mailboxes 8 to 15 the lower byte. The bit between the two groups is reserved.

Top module: `can_txq_regs`

## Requirements
- R1: After reset both registers read 0x0000, and `pend_mb` and `cxl_mb` are all zeros.
- R2: Register bit positions follow the mailbox number. Mailbox m in 1..7 sits at bit m+8, and mailbox m in 8..15 sits at bit m-8. On every mailbox-indexed vector port, bit i belongs to mailbox i+1.
- R3: Register bit 8 always reads 0, and a 1 written there changes nothing.
- R4: A write with `cpu_wr_en`=1 sets a flag on the next clock edge for each 1 in `cpu_wdata`. `cpu_sel`=0 selects the pending register and `cpu_sel`=1 selects the cancel register. `cpu_rdata` shows the selected register in the same cycle.
- R5: Writing 0 to a bit leaves that flag unchanged in both registers.
- R6: A `tx_done_mb` pulse clears that mailbox's pending flag on the next edge.
- R7: A `cxl_done_mb` pulse clears both the pending flag and the cancel flag of that mailbox on the next edge.
- R8: A cancel flag whose pending flag is 0 clears on the next edge. A cancel request on an idle mailbox is therefore seen for one cycle only.
- R9: Transmit-complete and cancel-complete pulses in the same cycle for one mailbox clear both of its flags.
- R10: When a software set and a hardware clear hit the same pending bit in the same cycle, the flag ends at 0.
- R11: A cancel flag holds at 1 while its pending flag is 1 and no completion pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Write strobe for the selected register |
| cpu_sel | input | 1 | Register select: 0 pending, 1 cancel |
| cpu_wdata | input | 16 | Write data; each 1 sets the mapped flag |
| cpu_rdata | output | 16 | Image of the selected register |
| tx_done_mb | input | 15 | Transmit-complete pulses, bit i = mailbox i+1 |
| cxl_done_mb | input | 15 | Cancel-complete pulses, bit i = mailbox i+1 |
| pend_mb | output | 15 | Pending flags, bit i = mailbox i+1 |
| cxl_mb | output | 15 | Cancel-request flags, bit i = mailbox i+1 |

## Verification
The bench walks every mailbox through both registers, one at a time. A mapping that was not swapped, or that was off by one, would light the wrong register bit or the wrong vector bit. After an all-ones write, the bench checks that reserved bit 8 still reads 0. It also drives a set and a clear into the same pending bit in one cycle. A design with the wrong priority would leave a stale pending flag.

The cancel handshake is covered three ways: a normal cancel completion, a transmit completion that overtakes a cancel, and both pulses in one cycle. A design that cleared cancel flags too early, or never cleared them, would show it on `cxl_mb`. The bench also requests a cancel on an idle mailbox, which must drop after exactly one cycle.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;
  localparam int unsigned CAN_NUM_MBX = 15;
  localparam int unsigned CAN_REG_W   = 16;
  localparam int unsigned CAN_RSV_BIT = 8;

  // Register bit that holds mailbox m (1-based): low mailboxes go to the
  // upper byte above the reserved bit, the rest fill the lower byte.
  function automatic int unsigned mbx_bit_pos(int unsigned m);
    if (m < CAN_RSV_BIT) return m + CAN_RSV_BIT;
    return m - CAN_RSV_BIT;
  endfunction
endpackage

// File: rtl/can_txq_unpack.sv
module can_txq_unpack
  import can_txq_pkg::*;
#(
  parameter int unsigned NUM_MBX = CAN_NUM_MBX,
  parameter int unsigned REG_W   = CAN_REG_W
) (
  input  logic [REG_W-1:0]   reg_in,
  output logic [NUM_MBX-1:0] mbx_out
);
  for (genvar m = 1; m <= NUM_MBX; m++) begin : g_bit
    localparam int unsigned POS = mbx_bit_pos(m);
    assign mbx_out[m-1] = reg_in[POS];
  end
endmodule

// File: rtl/can_txq_pack.sv
module can_txq_pack
  import can_txq_pkg::*;
#(
  parameter int unsigned NUM_MBX = CAN_NUM_MBX,
  parameter int unsigned REG_W   = CAN_REG_W,
  parameter int unsigned RSV_BIT = CAN_RSV_BIT
) (
  input  logic [NUM_MBX-1:0] mbx_in,
  output logic [REG_W-1:0]   reg_out
);
  assign reg_out[RSV_BIT] = 1'b0;
  for (genvar m = 1; m <= NUM_MBX; m++) begin : g_bit
    localparam int unsigned POS = mbx_bit_pos(m);
    assign reg_out[POS] = mbx_in[m-1];
  end
endmodule

// File: rtl/can_txq_cell.sv
module can_txq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pend,
  input  logic set_cxl,
  input  logic tx_done,
  input  logic cxl_done,
  output logic pend_q,
  output logic cxl_q,
  output logic pend_clr,
  output logic cxl_clr
);
  // Hardware clears win over software sets.
  assign pend_clr = tx_done | cxl_done;
  // Cancel handshake ends when engine reports it or pending is already gone.
  assign cxl_clr  = cxl_done | (cxl_q & ~pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cxl_q  <= 1'b0;
    end else begin
      pend_q <= pend_clr ? 1'b0 : (pend_q | set_pend);
      cxl_q  <= cxl_clr  ? 1'b0 : (cxl_q | set_cxl);
    end
  end
endmodule

// File: rtl/can_txq_regs.sv
module can_txq_regs
  import can_txq_pkg::*;
#(
  parameter int unsigned NUM_MBX = CAN_NUM_MBX,
  parameter int unsigned REG_W   = CAN_REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic               cpu_sel,
  input  logic [REG_W-1:0]   cpu_wdata,
  output logic [REG_W-1:0]   cpu_rdata,
  input  logic [NUM_MBX-1:0] tx_done_mb,
  input  logic [NUM_MBX-1:0] cxl_done_mb,
  output logic [NUM_MBX-1:0] pend_mb,
  output logic [NUM_MBX-1:0] cxl_mb
);
  logic [NUM_MBX-1:0] wr_mbx;
  logic [NUM_MBX-1:0] pend_set, cxl_set;
  logic [NUM_MBX-1:0] pend_clr, cxl_clr;
  logic [REG_W-1:0]   pend_img, cxl_img;

  can_txq_unpack #(.NUM_MBX(NUM_MBX), .REG_W(REG_W)) u_unpack (
    .reg_in (cpu_wdata),
    .mbx_out(wr_mbx)
  );

  assign pend_set = (cpu_wr_en && !cpu_sel) ? wr_mbx : '0;
  assign cxl_set  = (cpu_wr_en &&  cpu_sel) ? wr_mbx : '0;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_cell
    can_txq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_pend(pend_set[i]),
      .set_cxl (cxl_set[i]),
      .tx_done (tx_done_mb[i]),
      .cxl_done(cxl_done_mb[i]),
      .pend_q  (pend_mb[i]),
      .cxl_q   (cxl_mb[i]),
      .pend_clr(pend_clr[i]),
      .cxl_clr (cxl_clr[i])
    );
  end

  can_txq_pack #(.NUM_MBX(NUM_MBX), .REG_W(REG_W)) u_pack_pend (
    .mbx_in (pend_mb),
    .reg_out(pend_img)
  );
  can_txq_pack #(.NUM_MBX(NUM_MBX), .REG_W(REG_W)) u_pack_cxl (
    .mbx_in (cxl_mb),
    .reg_out(cxl_img)
  );

  assign cpu_rdata = cpu_sel ? cxl_img : pend_img;
endmodule

// File: rtl/can_txq_chk.sv
module can_txq_chk
  import can_txq_pkg::*;
#(
  parameter int unsigned NUM_MBX = CAN_NUM_MBX,
  parameter int unsigned REG_W   = CAN_REG_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [REG_W-1:0]   cpu_rdata,
  input logic [NUM_MBX-1:0] tx_done_mb,
  input logic [NUM_MBX-1:0] cxl_done_mb,
  input logic [NUM_MBX-1:0] pend_mb,
  input logic [NUM_MBX-1:0] cxl_mb,
  input logic [NUM_MBX-1:0] pend_set
);
  logic [NUM_MBX-1:0] hw_clr, set_only, cxl_idle, cxl_hold;
  assign hw_clr   = tx_done_mb | cxl_done_mb;
  assign set_only = pend_set & ~hw_clr;
  assign cxl_idle = cxl_mb & ~pend_mb;
  assign cxl_hold = cxl_mb & pend_mb & ~hw_clr;

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[CAN_RSV_BIT] == 1'b0);

  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_only) |=> ((pend_mb & $past(set_only)) == $past(set_only)));

  assert_hw_clr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |=> ((pend_mb & $past(hw_clr)) == '0));

  assert_cxl_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|cxl_done_mb) |=> ((cxl_mb & $past(cxl_done_mb)) == '0));

  assert_cxl_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cxl_idle) |=> ((cxl_mb & $past(cxl_idle)) == '0));

  assert_cxl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|cxl_hold) |=> ((cxl_mb & $past(cxl_hold)) == $past(cxl_hold)));
endmodule

bind can_txq_regs can_txq_chk #(.NUM_MBX(NUM_MBX), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_rdata  (cpu_rdata),
  .tx_done_mb (tx_done_mb),
  .cxl_done_mb(cxl_done_mb),
  .pend_mb    (pend_mb),
  .cxl_mb     (cxl_mb),
  .pend_set   (pend_set)
);

// File: tb/can_txq_regs_test.sv
module can_txq_regs_test;
  localparam int CLK_P = 10;
  localparam int NM    = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr_en = 1'b0;
  logic          cpu_sel = 1'b0;
  logic [15:0]   cpu_wdata = '0;
  logic [15:0]   cpu_rdata;
  logic [NM-1:0] tx_done_mb = '0;
  logic [NM-1:0] cxl_done_mb = '0;
  logic [NM-1:0] pend_mb, cxl_mb;

  int vectors = 0;
  int errors  = 0;
  logic [NM-1:0] mp = '0, mc = '0;   // bench model of both flag sets

  typedef struct {
    logic [NM-1:0] p;
    logic [NM-1:0] c;
    string         tag;
  } item_t;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  can_txq_regs uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_done_mb(tx_done_mb),
    .cxl_done_mb(cxl_done_mb), .pend_mb(pend_mb), .cxl_mb(cxl_mb)
  );

  // R2 mapping, restated: upper byte holds 1..7 from bit 9 up, lower byte 8..15
  function automatic int reg_pos(int m);
    return (m <= 7) ? (16 - 8 + m) : (m - 8);
  endfunction

  function automatic logic [15:0] img(logic [NM-1:0] v);
    logic [15:0] r = '0;
    for (int m = 1; m <= NM; m++) r[reg_pos(m)] = v[m-1];
    return r;
  endfunction

  function automatic logic [NM-1:0] mb(int m);
    logic [NM-1:0] v = '0;
    v[m-1] = 1'b1;
    return v;
  endfunction

  // Driver: one cycle of stimulus, read check, expected state pushed to scoreboard
  task automatic cyc(input logic wr, input logic sel, input logic [15:0] wd,
                     input logic [NM-1:0] tx, input logic [NM-1:0] cd, input string tag);
    logic [NM-1:0] np, nc;
    logic [15:0] exp_r;
    @(negedge clk);
    cpu_wr_en = wr; cpu_sel = sel; cpu_wdata = wd;
    tx_done_mb = tx; cxl_done_mb = cd;
    #1;
    exp_r = sel ? img(mc) : img(mp);
    vectors++;
    if (cpu_rdata !== exp_r) begin
      errors++;
      $display("FAIL %s rdata sel=%0d actual=%h expected=%h", tag, sel, cpu_rdata, exp_r);
    end
    for (int m = 1; m <= NM; m++) begin
      logic sp, sc, cp, cc;
      sp = wr && !sel && wd[reg_pos(m)];
      sc = wr &&  sel && wd[reg_pos(m)];
      cp = tx[m-1] || cd[m-1];
      cc = cd[m-1] || (mc[m-1] && !mp[m-1]);
      np[m-1] = cp ? 1'b0 : (mp[m-1] | sp);
      nc[m-1] = cc ? 1'b0 : (mc[m-1] | sc);
    end
    mp = np; mc = nc;
    sb.push_back('{p: np, c: nc, tag: tag});
  endtask

  task automatic idle(input logic sel, input string tag);
    cyc(1'b0, sel, 16'h0000, '0, '0, tag);
  endtask

  // Monitor: pops expectations after each edge and compares the flag vectors
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        vectors++;
        if (pend_mb !== it.p || cxl_mb !== it.c) begin
          errors++;
          $display("FAIL %s flags actual pend=%h cxl=%h expected pend=%h cxl=%h",
                   it.tag, pend_mb, cxl_mb, it.p, it.c);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of both registers and both vectors
    idle(1'b0, "R1");
    idle(1'b1, "R1");

    // R2: every mailbox through the pending register, then through the cancel register
    for (int m = 1; m <= NM; m++) begin
      cyc(1'b1, 1'b0, 16'h1 << reg_pos(m), '0, '0, "R2_R4");
      idle(1'b0, "R2");
      cyc(1'b0, 1'b0, 16'h0, mb(m), '0, "R6");
      cyc(1'b1, 1'b1, 16'h1 << reg_pos(m), '0, '0, "R2_R4");
      idle(1'b1, "R2_R8");
      idle(1'b1, "R8");
    end

    // R3: all ones into both registers, reserved bit stays 0
    cyc(1'b1, 1'b0, 16'hFFFF, '0, '0, "R3");
    idle(1'b0, "R3");
    cyc(1'b1, 1'b1, 16'hFFFF, '0, '0, "R3");
    idle(1'b1, "R3_R11");
    idle(1'b1, "R11");
    // R5: zeros change nothing
    cyc(1'b1, 1'b0, 16'h0000, '0, '0, "R5");
    cyc(1'b1, 1'b1, 16'h0000, '0, '0, "R5");
    idle(1'b0, "R5");
    // R7: normal cancel completion on mailbox 3
    cyc(1'b0, 1'b1, 16'h0, '0, mb(3), "R7");
    idle(1'b1, "R7");
    // R9: both pulses together on mailbox 10
    cyc(1'b0, 1'b0, 16'h0, mb(10), mb(10), "R9");
    idle(1'b1, "R9");
    // transmit wins the race against a cancel on mailbox 12, cancel then drops
    cyc(1'b0, 1'b0, 16'h0, mb(12), '0, "R6");
    idle(1'b1, "R8");
    idle(1'b1, "R8");
    // drain everything
    cyc(1'b0, 1'b0, 16'h0, '1, '0, "R6");
    idle(1'b1, "R8");
    idle(1'b0, "R6");
    // R10: set and clear on mailbox 5 in one cycle, plus set on 14 alone
    cyc(1'b1, 1'b0, (16'h1 << reg_pos(5)) | (16'h1 << reg_pos(14)), mb(5), '0, "R10");
    idle(1'b0, "R10");
    cyc(1'b0, 1'b0, 16'h0, mb(14), '0, "R6");
    idle(1'b0, "R6");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule